// File: doc/BRIEF.md
# Network Scan Test Wrapper

This block sits next to a network-on-chip switch and lets that switch be tested over the network. Test stimuli arrive as ordinary packets on a flit port. The wrapper removes the header and spreads each payload word across sixteen scan chains, one bit per chain, so that every chain shifts in the same cycle. After the last stimulus word it raises capture for one cycle. Scan-in and scan-out overlap: each stimulus word that is shifted in pushes one response word out. The wrapper packs these response words into a response packet addressed to a fixed diagnosis node.

A configuration packet writes a per-port defect mask that the switch reads. The wrapper also sends the mask on to a neighbour address so that nearby switches can use it. Any other packet type is read in and discarded. Outgoing flits go through a small FIFO, so the output port can apply backpressure. Backpressure reaches the input side only when the FIFO is full.

Flit layout: 26 bits. A header holds destination ID in [25:18], source ID in [17:10], type in [9:8] and length in [7:0]. A payload word sits in [15:0]. A separate tail bit travels with each flit.

Top module: `scan_pkt_wrapper`

## Requirements
- R1: For as long as `arst_n` is low, and for two clocks after it rises, `out_valid`, `scan_en` and `capture` are 0 and `defect_mask` is 0 (every port usable). After that, `in_ready` is 1.
- R2: The first flit of a packet is a header. Type 0 means stimulus, 1 means response, 2 means configuration and 3 is reserved. A header never drives `scan_en`.
- R3: For each stimulus payload flit that is accepted, `scan_en` is 1 and `scan_in[i]` equals payload bit i, both in the same cycle as the acceptance.
- R4: `scan_en` is 1 only in a cycle where a stimulus flit is accepted. While `in_valid` is low in the middle of a packet, the chains do not move.
- R5: In the cycle after a stimulus tail is accepted, `capture` is 1 for exactly one cycle. In that cycle `in_ready` is 0 and `scan_en` is 0.
- R6: Each stimulus packet produces one response packet. Its header is {DIAG_ID, NODE_ID, type 1, length CHAIN_LEN}. It is followed by one flit per stimulus word; each carries the `scan_out` value sampled in that shift cycle in bits [15:0]. The last flit has the tail bit set.
- R7: While `out_ready` is low, the current output flit stays the same. Flits are buffered in a FIFO and leave in order. `in_ready` falls when the FIFO is full, and no flit is lost.
- R8: In a configuration packet, bits [4:0] of the first payload flit set `defect_mask`. Bit 0 is north, 1 east, 2 south, 3 west and 4 local; a 1 marks the port as faulty. The new value appears on the clock that accepts the flit.
- R9: A configuration packet is forwarded as a header {NBR_ID, NODE_ID, type 2, length 1}, followed by one tail flit that carries the new mask in bits [4:0].
- R10: Packets of type 1 or 3 are read through to their tail and dropped. They cause no shift and no capture, produce no output flit, and leave the defect mask and the chain contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Wrapper accepts the incoming flit |
| in_data | input | 26 | Incoming flit |
| in_tail | input | 1 | Incoming flit ends its packet |
| out_valid | output | 1 | Outgoing flit valid |
| out_ready | input | 1 | Network accepts the outgoing flit |
| out_data | output | 26 | Outgoing flit |
| out_tail | output | 1 | Outgoing flit ends its packet |
| scan_en | output | 1 | Shift enable for all chains |
| scan_in | output | 16 | One stimulus bit per chain |
| scan_out | input | 16 | One response bit per chain (chain tail) |
| capture | output | 1 | Capture pulse to the switch under test |
| defect_mask | output | 5 | Stored per-port defect state |

## Verification
The hardest case to reach is a full output FIFO while a stimulus packet is still shifting in. It takes a stalled network port and an input that still has flits to offer. The bench holds `out_ready` low during a whole stimulus packet, so the response flits fill the buffer and the last stimulus word has to wait on `in_ready`. It then releases the port and checks the response word by word. Stalled input cycles in the middle of a packet are exercised separately. Each response is checked against the inverted stimulus of the packet before it, which shows that chain contents carry correctly from one packet to the next.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  localparam int ID_W   = 8;
  localparam int TYPE_W = 2;
  localparam int LEN_W  = 8;
  localparam int FLIT_W = 2 * ID_W + TYPE_W + LEN_W;

  typedef enum logic [TYPE_W-1:0] {
    PT_STIM = 2'd0,
    PT_RESP = 2'd1,
    PT_CFG  = 2'd2,
    PT_RSVD = 2'd3
  } pkt_type_e;

  function automatic logic [FLIT_W-1:0] pack_hdr(input logic [ID_W-1:0] dst,
                                                 input logic [ID_W-1:0] src,
                                                 input pkt_type_e typ,
                                                 input logic [LEN_W-1:0] len);
    return {dst, src, typ, len};
  endfunction
endpackage

// File: rtl/wrap_fifo.sv
module wrap_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    valid   = (cnt_q != '0);
    do_push = push && !full;
    do_pop  = pop && valid;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign data = mem[rd_q];
endmodule

// File: rtl/wrap_defect_reg.sv
module wrap_defect_reg #(
  parameter int MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MASK_W-1:0] d,
  output logic [MASK_W-1:0] q
);
  logic [MASK_W-1:0] q_d;

  always_comb q_d = we ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import wrap_pkg::*;
#(
  parameter int              CHAINS    = 16,
  parameter int              CHAIN_LEN = 4,
  parameter int              MASK_W    = 5,
  parameter logic [ID_W-1:0] NODE_ID   = 8'h21,
  parameter logic [ID_W-1:0] DIAG_ID   = 8'h00,
  parameter logic [ID_W-1:0] NBR_ID    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_tail,
  input  logic [TYPE_W-1:0] in_type,
  input  logic [CHAINS-1:0] in_pay,
  output logic              in_ready,
  input  logic              fifo_full,
  output logic              push,
  output logic [FLIT_W-1:0] push_data,
  output logic              push_tail,
  output logic              scan_en,
  output logic [CHAINS-1:0] scan_in,
  input  logic [CHAINS-1:0] scan_out,
  output logic              capture,
  output logic              mask_we
);
  typedef enum logic [2:0] {S_HDR, S_STIM, S_CAPT, S_CFG, S_DROP} st_e;

  st_e       st_q, st_d;
  logic      first_q, first_d;
  logic      acc;
  pkt_type_e ptype;

  assign scan_in = in_pay;

  always_comb begin
    ptype     = pkt_type_e'(in_type);
    in_ready  = !fifo_full && (st_q != S_CAPT);
    acc       = in_valid && in_ready;
    st_d      = st_q;
    first_d   = first_q;
    scan_en   = 1'b0;
    capture   = 1'b0;
    push      = 1'b0;
    push_data = '0;
    push_tail = 1'b0;
    mask_we   = 1'b0;
    case (st_q)
      S_HDR: if (acc) begin
        case (ptype)
          PT_STIM: begin
            push      = 1'b1;
            push_data = pack_hdr(DIAG_ID, NODE_ID, PT_RESP, LEN_W'(CHAIN_LEN));
            st_d      = S_STIM;
          end
          PT_CFG: begin
            push      = 1'b1;
            push_data = pack_hdr(NBR_ID, NODE_ID, PT_CFG, LEN_W'(1));
            first_d   = 1'b1;
            st_d      = S_CFG;
          end
          default: st_d = in_tail ? S_HDR : S_DROP;
        endcase
      end
      S_STIM: if (acc) begin
        scan_en   = 1'b1;
        push      = 1'b1;
        push_data = FLIT_W'(scan_out);
        push_tail = in_tail;
        if (in_tail) st_d = S_CAPT;
      end
      S_CAPT: begin
        capture = 1'b1;
        st_d    = S_HDR;
      end
      S_CFG: if (acc) begin
        if (first_q) begin
          mask_we   = 1'b1;
          push      = 1'b1;
          push_data = FLIT_W'(in_pay[MASK_W-1:0]);
          push_tail = 1'b1;
          first_d   = 1'b0;
        end
        if (in_tail) st_d = S_HDR;
      end
      S_DROP: if (acc && in_tail) st_d = S_HDR;
      default: st_d = S_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_HDR;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/scan_pkt_wrapper.sv
module scan_pkt_wrapper
  import wrap_pkg::*;
#(
  parameter int              CHAINS     = 16,
  parameter int              CHAIN_LEN  = 4,
  parameter int              MASK_W     = 5,
  parameter int              FIFO_DEPTH = 4,
  parameter logic [ID_W-1:0] NODE_ID    = 8'h21,
  parameter logic [ID_W-1:0] DIAG_ID    = 8'h00,
  parameter logic [ID_W-1:0] NBR_ID     = 8'hFF
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_tail,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_tail,
  output logic              scan_en,
  output logic [CHAINS-1:0] scan_in,
  input  logic [CHAINS-1:0] scan_out,
  output logic              capture,
  output logic [MASK_W-1:0] defect_mask
);
  logic [1:0]        rst_sync;
  logic              rst_n;
  logic              ctl_push, ctl_tail, fifo_full, mask_we;
  logic [FLIT_W-1:0] ctl_data;
  logic              hdr_unused;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  assign hdr_unused = ^in_data[FLIT_W-1:CHAINS];

  wrap_ctrl #(
    .CHAINS(CHAINS), .CHAIN_LEN(CHAIN_LEN), .MASK_W(MASK_W),
    .NODE_ID(NODE_ID), .DIAG_ID(DIAG_ID), .NBR_ID(NBR_ID)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_tail(in_tail),
    .in_type(in_data[LEN_W +: TYPE_W]), .in_pay(in_data[CHAINS-1:0]),
    .in_ready(in_ready), .fifo_full(fifo_full),
    .push(ctl_push), .push_data(ctl_data), .push_tail(ctl_tail),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .capture(capture), .mask_we(mask_we)
  );

  wrap_fifo #(.W(FLIT_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(ctl_push), .push_data({ctl_tail, ctl_data}), .full(fifo_full),
    .pop(out_ready), .valid(out_valid), .data({out_tail, out_data})
  );

  wrap_defect_reg #(.MASK_W(MASK_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we),
    .d(in_data[MASK_W-1:0]), .q(defect_mask)
  );
endmodule

// File: rtl/wrap_chk.sv
module wrap_chk #(
  parameter int FW = 26,
  parameter int MW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_tail,
  input logic          out_valid,
  input logic          out_ready,
  input logic [FW-1:0] out_data,
  input logic          out_tail,
  input logic          scan_en,
  input logic          capture,
  input logic [MW-1:0] defect_mask,
  input logic          push,
  input logic          fifo_full
);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tail)));

  p_shift_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (in_valid && in_ready));

  p_capture_after_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> ($past(in_valid && in_ready && in_tail) && !in_ready && !scan_en));

  p_capture_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture);

  p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> $stable(defect_mask));
endmodule

bind scan_pkt_wrapper wrap_chk #(.FW(wrap_pkg::FLIT_W), .MW(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_tail(in_tail), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_tail(out_tail), .scan_en(scan_en),
  .capture(capture), .defect_mask(defect_mask), .push(ctl_push),
  .fifo_full(fifo_full)
);

// File: tb/sim_scan_pkt_wrapper.sv
`timescale 1ns/1ps
module sim_scan_pkt_wrapper;
  import wrap_pkg::*;

  localparam int L = 4;
  localparam int NCH = 16;
  localparam int MW = 5;
  localparam logic [7:0] NODE = 8'h21, DIAG = 8'h00, NBR = 8'hFF;

  // {stimulus word, expected response word (inverse of previous packet)}
  localparam logic [31:0] VEC [12] = '{
    32'h0001_0000, 32'h8000_0000, 32'hA5A5_0000, 32'hFFFF_0000,
    32'h1234_FFFE, 32'h0000_7FFF, 32'h5A5A_5A5A, 32'hC3C3_0000,
    32'h00FF_EDCB, 32'hF0F0_FFFF, 32'h0F0F_A5A5, 32'h7E81_3C3C
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              arst_n, in_valid, in_ready, in_tail;
  logic [FLIT_W-1:0] in_data, out_data;
  logic              out_valid, out_ready, out_tail;
  logic              scan_en, capture;
  logic [NCH-1:0]    scan_in, scan_out;
  logic [MW-1:0]     defect_mask;

  scan_pkt_wrapper u0 (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tail(in_tail), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_tail(out_tail),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out),
    .capture(capture), .defect_mask(defect_mask)
  );

  // scan chain model: shift toward bit L-1, capture inverts contents
  logic [L-1:0] chain [NCH];
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < NCH; i++) chain[i] <= '0;
    end else if (scan_en) begin
      for (int i = 0; i < NCH; i++) chain[i] <= {chain[i][L-2:0], scan_in[i]};
    end else if (capture) begin
      for (int i = 0; i < NCH; i++) chain[i] <= ~chain[i];
    end
  end
  always_comb for (int i = 0; i < NCH; i++) scan_out[i] = chain[i][L-1];

  int checks = 0, errors = 0, log_n = 0, cap_n = 0;
  bit done = 0;
  logic [FLIT_W-1:0] log_d [64];
  logic              log_t [64];

  always @(negedge clk) begin
    if (out_valid && out_ready) begin
      if (log_n < 64) begin
        log_d[log_n] = out_data;
        log_t[log_n] = out_tail;
      end
      log_n++;
    end
    if (capture) cap_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [FLIT_W-1:0] d, input logic t, input bit stim, input string req);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_tail = t;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    if (stim) chk(scan_en === 1'b1 && scan_in === d[15:0], req, {15'd0, scan_en, scan_in}, {15'd0, 1'b1, d[15:0]});
    else      chk(scan_en === 1'b0, req, {31'd0, scan_en}, 32'd0);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_tail = 1'b0;
  endtask

  task automatic send_pkt(input logic [15:0] w [L], input bit gap);
    send(pack_hdr(NODE, 8'h05, PT_STIM, 8'(L)), 1'b0, 1'b0, "R2 stim header no shift");
    for (int k = 0; k < L; k++) begin
      send(FLIT_W'(w[k]), (k == L - 1), 1'b1, "R3 parallel load");
      if (gap && k != L - 1) begin
        idle();
        @(negedge clk);
        chk(scan_en === 1'b0, "R4 no shift while idle", {31'd0, scan_en}, 32'd0);
        @(negedge clk);
      end
    end
    idle();
    @(negedge clk);
    chk(capture === 1'b1 && in_ready === 1'b0, "R5 capture pulse", {30'd0, capture, in_ready}, 32'h2);
    @(negedge clk);
    chk(capture === 1'b0, "R5 capture single", {31'd0, capture}, 32'd0);
  endtask

  task automatic expect_resp(input int base, input logic [15:0] e [L]);
    chk(log_d[base] === pack_hdr(DIAG, NODE, PT_RESP, 8'(L)) && log_t[base] === 1'b0,
        "R6 response header", 32'(log_d[base]), 32'(pack_hdr(DIAG, NODE, PT_RESP, 8'(L))));
    for (int k = 0; k < L; k++)
      chk(log_d[base + 1 + k] === FLIT_W'(e[k]) && log_t[base + 1 + k] === (k == L - 1),
          "R6 response word", {5'd0, log_t[base + 1 + k], log_d[base + 1 + k]},
          {5'd0, 1'(k == L - 1), FLIT_W'(e[k])});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w [L];
    logic [15:0] e [L];
    logic [FLIT_W-1:0] held;
    int n0, c0;
    arst_n = 1'b0; in_valid = 1'b0; in_tail = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0 && scan_en === 1'b0 && capture === 1'b0 && defect_mask === '0,
        "R1 reset outputs", {28'd0, out_valid, scan_en, capture, |defect_mask}, 32'd0);
    @(posedge clk); #1 arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0 && defect_mask === '0,
        "R1 after reset", {30'd0, in_ready, out_valid}, 32'h2);

    // table walk: three stimulus packets with the port always ready
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < L; k++) w[k] = VEC[p * L + k][31:16];
      send_pkt(w, 1'b0);
    end
    repeat (8) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < L; k++) e[k] = VEC[p * L + k][15:0];
      expect_resp(p * (L + 1), e);
    end

    // R4: stalled input between flits
    w = '{16'h1357, 16'h2468, 16'hFACE, 16'h0BAD};
    send_pkt(w, 1'b1);
    repeat (8) @(negedge clk);
    e = '{16'hFF00, 16'h0F0F, 16'hF0F0, 16'h817E};
    expect_resp(15, e);

    // R7: output backpressure fills the buffer mid-packet
    @(posedge clk); #1 out_ready = 1'b0;
    w = '{16'h3333, 16'hCCCC, 16'h0F00, 16'h00F0};
    fork
      send_pkt(w, 1'b0);
      begin
        repeat (12) @(negedge clk);
        chk(in_ready === 1'b0, "R7 full blocks input", {31'd0, in_ready}, 32'd0);
        held = out_data;
        @(negedge clk);
        chk(out_valid === 1'b1 && out_data === held, "R7 output held", 32'(out_data), 32'(held));
        @(posedge clk); #1 out_ready = 1'b1;
      end
    join
    repeat (8) @(negedge clk);
    e = '{16'hECA8, 16'hDB97, 16'h0531, 16'hF452};
    expect_resp(20, e);

    // R8/R9: configuration packet
    send(pack_hdr(NODE, 8'h07, PT_CFG, 8'd1), 1'b0, 1'b0, "R2 cfg header no shift");
    send(FLIT_W'(5'b10110), 1'b1, 1'b0, "R8 cfg payload no shift");
    idle();
    @(negedge clk);
    chk(defect_mask === 5'b10110, "R8 mask stored", 32'(defect_mask), 32'h16);
    repeat (6) @(negedge clk);
    chk(log_d[25] === pack_hdr(NBR, NODE, PT_CFG, 8'd1) && log_t[25] === 1'b0,
        "R9 forward header", 32'(log_d[25]), 32'(pack_hdr(NBR, NODE, PT_CFG, 8'd1)));
    chk(log_d[26] === FLIT_W'(5'b10110) && log_t[26] === 1'b1,
        "R9 forward mask", 32'(log_d[26]), 32'h16);

    // R10: reserved and response-type packets are dropped
    n0 = log_n; c0 = cap_n;
    send(pack_hdr(NODE, 8'h09, PT_RSVD, 8'd2), 1'b0, 1'b0, "R10 reserved header");
    send(FLIT_W'(16'hFFFF), 1'b0, 1'b0, "R10 reserved no shift");
    send(FLIT_W'(16'h0001), 1'b1, 1'b0, "R10 reserved no shift");
    send(pack_hdr(NODE, 8'h09, PT_RESP, 8'd1), 1'b0, 1'b0, "R10 resp header");
    send(FLIT_W'(16'h0003), 1'b1, 1'b0, "R10 resp no shift");
    idle();
    repeat (6) @(negedge clk);
    chk(log_n == n0, "R10 no output", 32'(log_n), 32'(n0));
    chk(cap_n == c0, "R10 no capture", 32'(cap_n), 32'(c0));
    chk(defect_mask === 5'b10110, "R10 mask kept", 32'(defect_mask), 32'h16);
    w = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
    send_pkt(w, 1'b0);
    repeat (8) @(negedge clk);
    e = '{16'hCCCC, 16'h3333, 16'hF0FF, 16'hFF0F};
    expect_resp(27, e);
    chk(log_n == 32, "R6 total flits", 32'(log_n), 32'd32);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule